// File: doc/BRIEF.md
# Banked GPIO with Interrupt Detection

This block is one bank of 32 general-purpose pins behind a 32-bit register port. Software sets the output value and the output enable of each pin and reads back the pin levels. Each input passes through a two-flop synchronizer before any logic sees it. The bank also watches every pin for an interrupt condition. Each pin has its own trigger mode: high level, low level, rising edge, falling edge, or both edges.

Three per-pin configuration words pick the trigger: a sense-kind word, a both-edges word and a polarity word. A detected condition latches into a raw pending word. The raw word is ANDed with an enable word to form the masked pending word. Software clears pending bits by writing ones to a write-one-to-clear location. The block drives a single interrupt line, which is the registered OR of the masked pending bits.

The byte offset is decoded over a 0x200-byte window, which is the spacing between banks. Selecting among banks is left to the surrounding fabric. Read data is combinational from the offset, and writes take effect at the clock edge where the write strobe is high.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low. So every pin is an input, configured for falling-edge detection, and masked.
- R2: The byte offsets are: 0x00 synchronized pin levels, 0x04 output value, 0x08 output enable, 0x0C sense kind, 0x10 both-edges, 0x14 polarity, 0x18 enable mask, 0x1C raw pending, 0x20 masked pending, 0x24 clear. A pin level change appears at offset 0x00 two clock edges after it reaches `pin_in`. Offset 0x24 and any undefined offset read zero.
- R3: `pin_oe` equals the output-enable word. Bit n of `pin_out` equals output-value bit n when output-enable bit n is 1, and is 0 otherwise.
- R4: With sense-kind bit 0 and both-edges bit 0, a polarity bit of 1 flags a rising edge and a polarity bit of 0 flags a falling edge. An edge is a change between two successive synchronized samples. A transition in the other direction leaves the pending bit unchanged.
- R5: With sense-kind bit 0 and both-edges bit 1, the pin flags on both rising and falling transitions, whatever its polarity bit holds.
- R6: With sense-kind bit 1, the pin flags on every cycle its synchronized level equals its polarity bit (1 = active high, 0 = active low). A clear while the level is still active leaves the pending bit set.
- R7: The masked pending word equals raw pending AND the enable mask. `irq` is high exactly one cycle after the masked pending word is non-zero.
- R8: Writing 1 to a bit at offset 0x24 clears that pending bit, and writing 0 leaves it unchanged. A new condition detected in the same cycle as a clear of its bit wins, and the bit stays set.
- R9: Writes to offsets 0x00, 0x1C and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset within the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output value, gated by output enable |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Registered OR of the masked pending bits |

## Verification
Several properties are checked on every cycle. A pending bit never rises without a detected condition in the cycle before. It never falls without a clear of that bit. A detected condition always leaves its bit set. `irq` tracks the masked pending word one cycle later. Gated outputs never drive a pin that is not enabled, and the clear location always reads zero. Only the bench's scenarios can show that the right condition fires for each trigger mode, and the two-edge timing from pin to register. They also cover the exact collision between a new edge and a clear, the re-flagging of an active level, and the ignored writes to read-only locations.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_PINS = 32;

    localparam int OFS_LEVEL = 'h00;
    localparam int OFS_DOUT  = 'h04;
    localparam int OFS_OE    = 'h08;
    localparam int OFS_KIND  = 'h0C;
    localparam int OFS_BOTH  = 'h10;
    localparam int OFS_POL   = 'h14;
    localparam int OFS_MASK  = 'h18;
    localparam int OFS_RAW   = 'h1C;
    localparam int OFS_MSK   = 'h20;
    localparam int OFS_CLR   = 'h24;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DOUT,
        SEL_OE,
        SEL_KIND,
        SEL_BOTH,
        SEL_POL,
        SEL_MASK,
        SEL_RAW,
        SEL_MSK,
        SEL_CLR
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_PINS-1:0] dout;
        logic [BANK_PINS-1:0] oe;
        logic [BANK_PINS-1:0] kind;
        logic [BANK_PINS-1:0] both;
        logic [BANK_PINS-1:0] pol;
        logic [BANK_PINS-1:0] mask;
    } bank_cfg_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_in;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [BANK_PINS-1:0] wdata,
    output bank_cfg_t            cfg
);
    bank_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_DOUT: cfg_d.dout = wdata;
                SEL_OE:   cfg_d.oe   = wdata;
                SEL_KIND: cfg_d.kind = wdata;
                SEL_BOTH: cfg_d.both = wdata;
                SEL_POL:  cfg_d.pol  = wdata;
                SEL_MASK: cfg_d.mask = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] kind,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] clr,
    output logic [W-1:0] evt,
    output logic [W-1:0] raw,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] raw;
        logic         irq;
    } det_state_t;

    det_state_t st_d, st_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_w, fall_w, lvl_w, edg_w;
        assign rise_w = smp[i] & ~st_q.prev[i];
        assign fall_w = ~smp[i] & st_q.prev[i];
        assign lvl_w  = pol[i] ? smp[i] : ~smp[i];
        assign edg_w  = both[i] ? (rise_w | fall_w) : (pol[i] ? rise_w : fall_w);
        assign evt[i] = kind[i] ? lvl_w : edg_w;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
        st_d.raw  = (st_q.raw & ~clr) | evt;
        st_d.irq  = |(st_q.raw & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = st_q.raw;
    assign irq = st_q.irq;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BANK_PINS-1:0] bus_wdata,
    output logic [BANK_PINS-1:0] bus_rdata,
    input  logic [BANK_PINS-1:0] pin_in,
    output logic [BANK_PINS-1:0] pin_out,
    output logic [BANK_PINS-1:0] pin_oe,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
    localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);
    localparam logic [ADDR_W-1:0] A_KIND  = ADDR_W'(OFS_KIND);
    localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

    reg_sel_e             sel;
    bank_cfg_t            cfg;
    logic [BANK_PINS-1:0] smp;
    logic [BANK_PINS-1:0] clr_vec;
    logic [BANK_PINS-1:0] det_evt;
    logic [BANK_PINS-1:0] stat_raw;
    logic [BANK_PINS-1:0] cfg_mask;

    always_comb begin
        case (bus_addr)
            A_LEVEL: sel = SEL_LEVEL;
            A_DOUT:  sel = SEL_DOUT;
            A_OE:    sel = SEL_OE;
            A_KIND:  sel = SEL_KIND;
            A_BOTH:  sel = SEL_BOTH;
            A_POL:   sel = SEL_POL;
            A_MASK:  sel = SEL_MASK;
            A_RAW:   sel = SEL_RAW;
            A_MSK:   sel = SEL_MSK;
            A_CLR:   sel = SEL_CLR;
            default: sel = SEL_NONE;
        endcase
    end

    assign clr_vec  = (bus_wr && sel == SEL_CLR) ? bus_wdata : '0;
    assign cfg_mask = cfg.mask;

    gpio_in_sync #(
        .W      (BANK_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (smp)
    );

    gpio_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    gpio_irq_detect #(
        .W (BANK_PINS)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .kind  (cfg.kind),
        .both  (cfg.both),
        .pol   (cfg.pol),
        .mask  (cfg.mask),
        .clr   (clr_vec),
        .evt   (det_evt),
        .raw   (stat_raw),
        .irq   (irq)
    );

    always_comb begin
        case (sel)
            SEL_LEVEL: bus_rdata = smp;
            SEL_DOUT:  bus_rdata = cfg.dout;
            SEL_OE:    bus_rdata = cfg.oe;
            SEL_KIND:  bus_rdata = cfg.kind;
            SEL_BOTH:  bus_rdata = cfg.both;
            SEL_POL:   bus_rdata = cfg.pol;
            SEL_MASK:  bus_rdata = cfg.mask;
            SEL_RAW:   bus_rdata = stat_raw;
            SEL_MSK:   bus_rdata = stat_raw & cfg.mask;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_oe  = cfg.oe;
    assign pin_out = cfg.dout & cfg.oe;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe,
    input logic              irq,
    input logic [31:0]       stat_raw,
    input logic [31:0]       cfg_mask,
    input logic [31:0]       det_evt,
    input logic [31:0]       clr_vec
);
    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == 32'h0);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(stat_raw & cfg_mask)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_raw & ~$past(stat_raw) & ~$past(det_evt)) == 32'h0);

    // R8
    no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_raw) & ~stat_raw & ~$past(clr_vec)) == 32'h0);

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(det_evt) & ~stat_raw) == 32'h0);

    // R2
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h24)) |-> (bus_rdata == 32'h0));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat_raw  (stat_raw),
    .cfg_mask  (cfg_mask),
    .det_evt   (det_evt),
    .clr_vec   (clr_vec)
);

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = 9'h1C;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_irq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev;
    logic [31:0] m_dout, m_oe, m_kind, m_both, m_pol, m_mask, m_raw;
    logic        m_irq;

    initial begin
        {m_s1, m_s2, m_prev, m_dout, m_oe, m_kind, m_both, m_pol, m_mask, m_raw} = '0;
        m_irq = 1'b0;
    end

    function automatic logic [31:0] m_read(input logic [8:0] a);
        case (a)
            9'h00: return m_s2;
            9'h04: return m_dout;
            9'h08: return m_oe;
            9'h0C: return m_kind;
            9'h10: return m_both;
            9'h14: return m_pol;
            9'h18: return m_mask;
            9'h1C: return m_raw;
            9'h20: return m_raw & m_mask;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] ev, clr, nraw;
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_dout, m_oe, m_kind, m_both, m_pol, m_mask, m_raw} = '0;
            m_irq = 1'b0;
        end else begin
            ev = '0;
            for (int p = 0; p < 32; p++) begin
                bit now_hi, was_hi, flag;
                now_hi = m_s2[p];
                was_hi = m_prev[p];
                if (m_kind[p])      flag = (now_hi == m_pol[p]);
                else if (m_both[p]) flag = (now_hi != was_hi);
                else if (m_pol[p])  flag = now_hi && !was_hi;
                else                flag = !now_hi && was_hi;
                ev[p] = flag;
            end
            clr  = (bus_wr && bus_addr == 9'h24) ? bus_wdata : 32'h0;
            nraw = (m_raw & ~clr) | ev;
            m_irq = ((m_raw & m_mask) != 0);
            m_raw = nraw;
            if (bus_wr) begin
                case (bus_addr)
                    9'h04: m_dout = bus_wdata;
                    9'h08: m_oe   = bus_wdata;
                    9'h0C: m_kind = bus_wdata;
                    9'h10: m_both = bus_wdata;
                    9'h14: m_pol  = bus_wdata;
                    9'h18: m_mask = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            chk("R3 pin_out vs model", pin_out, m_dout & m_oe);
            chk("R3 pin_oe vs model", pin_oe, m_oe);
            chk("R2 rdata vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #2;
        bus_wr = 1'b0; bus_addr = 9'h1C;
    endtask

    task automatic rd(input logic [8:0] a, input string tag, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_addr = 9'h1C;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        for (int a = 0; a <= 'h24; a += 4) rd(9'(a), "R1 reset read", 32'h0);
        chk("R1 irq low", {31'h0, irq}, 32'h0);
        chk("R1 pin_oe zero", pin_oe, 32'h0);

        // R3 output gating, R2 readback
        wr(9'h08, 32'h0000FF00);
        wr(9'h04, 32'h12345678);
        rd(9'h04, "R2 dout readback", 32'h12345678);
        rd(9'h08, "R2 oe readback", 32'h0000FF00);
        chk("R3 pin_out gated", pin_out, 32'h00005600);
        chk("R3 pin_oe", pin_oe, 32'h0000FF00);

        // R2 two-edge input latency
        pin_in = 32'hA5A50000;
        wait_cyc(1);
        rd(9'h00, "R2 level after one edge", 32'h0);
        wait_cyc(1);
        rd(9'h00, "R2 level after two edges", 32'hA5A50000);
        rd(9'h1C, "R4 rising ignored in falling mode", 32'h0);
        pin_in = 32'h0;
        wait_cyc(3);
        rd(9'h1C, "R4 falling default flags", 32'hA5A50000);
        wr(9'h24, 32'h0000FFFF);
        rd(9'h1C, "R8 zero bits do not clear", 32'hA5A50000);
        wr(9'h24, 32'hA5A50000);
        rd(9'h1C, "R8 ones clear", 32'h0);

        // R9 read-only locations
        wr(9'h00, 32'hFFFFFFFF);
        wr(9'h1C, 32'hFFFFFFFF);
        wr(9'h20, 32'hFFFFFFFF);
        rd(9'h00, "R9 level unchanged", 32'h0);
        rd(9'h1C, "R9 raw unchanged", 32'h0);
        rd(9'h20, "R9 masked unchanged", 32'h0);
        rd(9'h04, "R9 dout unchanged", 32'h12345678);

        // R7 mask and interrupt, pin 3 falling
        wr(9'h18, 32'h00000008);
        pin_in[3] = 1'b1;
        wait_cyc(3);
        rd(9'h1C, "R4 pin3 rise ignored", 32'h0);
        pin_in[3] = 1'b0;
        wait_cyc(3);
        rd(9'h1C, "R4 pin3 falling", 32'h00000008);
        rd(9'h20, "R7 masked", 32'h00000008);
        chk("R7 irq one cycle late", {31'h0, irq}, 32'h0);
        wait_cyc(1);
        chk("R7 irq high", {31'h0, irq}, 32'h1);
        wr(9'h24, 32'h00000008);
        chk("R7 irq holds one cycle", {31'h0, irq}, 32'h1);
        wait_cyc(1);
        chk("R7 irq drops", {31'h0, irq}, 32'h0);

        // R4 rising on pin 5
        wr(9'h14, 32'h00000020);
        pin_in[5] = 1'b1;
        wait_cyc(3);
        rd(9'h1C, "R4 pin5 rising", 32'h00000020);
        rd(9'h20, "R7 pin5 masked off", 32'h0);
        chk("R7 masked pin no irq", {31'h0, irq}, 32'h0);
        wr(9'h24, 32'h00000020);
        pin_in[5] = 1'b0;
        wait_cyc(3);
        rd(9'h1C, "R4 pin5 fall ignored", 32'h0);

        // R5 both edges on pin 7, polarity set
        wr(9'h10, 32'h00000080);
        wr(9'h14, 32'h000000A0);
        pin_in[7] = 1'b1;
        wait_cyc(3);
        rd(9'h1C, "R5 pin7 rise", 32'h00000080);
        wr(9'h24, 32'h00000080);
        pin_in[7] = 1'b0;
        wait_cyc(3);
        rd(9'h1C, "R5 pin7 fall", 32'h00000080);
        wr(9'h24, 32'h00000080);

        // R6 level high on pin 9
        wr(9'h14, 32'h000002A0);
        wr(9'h0C, 32'h00000200);
        wait_cyc(1);
        rd(9'h1C, "R6 inactive level", 32'h0);
        pin_in[9] = 1'b1;
        wait_cyc(3);
        rd(9'h1C, "R6 level high", 32'h00000200);
        wr(9'h24, 32'h00000200);
        rd(9'h1C, "R6 active level re-flags", 32'h00000200);
        pin_in[9] = 1'b0;
        wait_cyc(3);
        wr(9'h24, 32'h00000200);
        rd(9'h1C, "R6 cleared after release", 32'h0);

        // R6 level low on pin 10
        wr(9'h0C, 32'h00000600);
        wait_cyc(1);
        rd(9'h1C, "R6 level low", 32'h00000400);
        pin_in[10] = 1'b1;
        wait_cyc(3);
        wr(9'h24, 32'h00000400);
        rd(9'h1C, "R6 low released", 32'h0);

        // R8 clear in the same cycle as a new edge on pin 3
        pin_in[3] = 1'b1;
        wait_cyc(4);
        wr(9'h24, 32'hFFFFFFFF);
        pin_in[3] = 1'b0;
        wait_cyc(2);
        wr(9'h24, 32'h00000008);
        rd(9'h1C, "R8 edge beats clear", 32'h00000008);
        wr(9'h24, 32'h00000008);
        pin_in[3] = 1'b1;
        wait_cyc(4);
        pin_in[3] = 1'b0;
        wait_cyc(3);
        wr(9'h24, 32'h00000008);
        rd(9'h1C, "R8 clear after edge", 32'h0);

        wait_cyc(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule